// File: doc/BRIEF.md
# Low-Region Chip Select Unit

This unit watches processor bus cycles and drives an active-low chip select for any access that falls in a memory region based at address zero. A single control register sets the region size, the number of wait states added to each access, and whether the external ready line is honoured. The ready line the unit returns to the bus unit combines the wait-state count with external ready. A further control bit asks the bus unit to leave out the address phase on the multiplexed address/data bus, but it has effect only if a strap input was high when reset was released.

After reset the chip select is held inactive, and the control register holds no usable configuration. The chip select becomes live the first time software reads or writes the control register. A bus cycle is opened by a one-cycle `bus_start` strobe that carries the address. It is closed by the first cycle in which `rdy_out` is high. A new cycle is started only after the previous one has closed.

Top module: `lrcs_unit`

## Requirements
- R1: The region begins at 00000h. Its end is set by the 3-bit size field, held in control bits 14..12: code 000 ends at 0FFFFh, 001 at 1FFFFh, 011 at 3FFFFh and 111 at 7FFFFh. Any other code works as a mask on address bits 18..16. An address is inside the region only when bit 19 is 0 and bits 18..16 have no bit set in a position where the code has a 0.
- R2: From reset until the first read or write of the control register, `cs_n` stays high for every bus cycle. After that first access, the chip select is live until the next reset.
- R3: With external ready ignored, `rdy_out` first rises W cycles after the cycle in which `cs_n` falls. W is the wait field in control bits 1..0, and codes 00/01/10/11 give 0/1/2/3 wait states.
- R4: When the ready-mode bit (control bit 2) is 1, the level of `ext_rdy` has no effect on when `rdy_out` rises.
- R5: When the ready-mode bit is 0, `rdy_out` is high only in cycles where the programmed wait states have elapsed and `ext_rdy` is high.
- R6: `strap_addr_en` is sampled in the last cycle of reset. If it was sampled high, `addr_off` equals the disable-address bit (control bit 7) in every cycle where `cs_n` is low. If it was sampled low, `addr_off` stays 0.
- R7: `reg_rdata` returns the control fields at their bit positions, with bits 15, 11..8 and 5..3 always read as 1. The PSRAM-enable bit (bit 6) is stored and read back but has no other effect. The value after reset is 8F38h.
- R8: `cs_n` falls in the cycle after `bus_start` for an address inside the region. It stays low up to and including the cycle in which `rdy_out` is high, and rises in the cycle after that. For addresses outside the region, `cs_n` stays high and `rdy_out` stays low.
- R9: If a register access and a `bus_start` fall in the same cycle, that bus cycle is decoded with the configuration and enable state from before the register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr_en | input | 1 | Strap input, captured when reset is released |
| bus_start | input | 1 | One-cycle strobe that opens a bus cycle |
| bus_addr | input | 20 | Byte address, valid with `bus_start` |
| ext_rdy | input | 1 | External ready from the addressed device |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read data |
| cs_n | output | 1 | Active-low chip select for the region |
| rdy_out | output | 1 | Combined ready to the bus unit |
| addr_off | output | 1 | Request to suppress the address phase |

## Verification
The two functions that can land in the same cycle are a control-register access and the start of a bus cycle. The bench causes this by driving `reg_wr` and `bus_start` on the same edge twice. The first time is straight after reset, when the write is also the first touch of the register. The second time is while the write widens the region so that it covers the address being started. In both cases the bench expects the chip select to stay high, because the old enable state and the old size still apply. It then expects an identical access started one cycle later to assert the chip select.

// File: rtl/lrcs_pkg.sv
// Package: lrcs_pkg
// Shared constants and types for the low-region chip select unit.
// Assumes a 16-bit control register with a fixed field layout.
package lrcs_pkg;

    localparam int REG_W    = 16;
    localparam int SIZE_W   = 3;
    localparam int WS_W     = 2;

    // Field positions inside the control word
    localparam int SIZE_LSB = 12;
    localparam int DA_BIT   = 7;
    localparam int PS_BIT   = 6;
    localparam int RM_BIT   = 2;
    localparam int WS_LSB   = 0;

    // Bits that always read back as one
    localparam logic [REG_W-1:0] RSV_MASK = 16'h8F38;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              dis_addr;
        logic              psram;
        logic              rdy_ign;
        logic [WS_W-1:0]   ws;
    } lrcs_cfg_t;

endpackage

// File: rtl/lrcs_cfg_reg.sv
// Module: lrcs_cfg_reg
// Holds the control register, the enable flag that is set on the first
// access, and the strap value captured at reset release.
// Assumes reg_wr and reg_rd are one-cycle strobes and rst_n is synchronous.
module lrcs_cfg_reg
    import lrcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_in,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [SIZE_W-1:0] size,
    output logic             dis_addr,
    output logic             rdy_ign,
    output logic [WS_W-1:0]  ws,
    output logic             cs_enable,
    output logic             strap_q
);

    lrcs_cfg_t cfg_q;
    logic      en_q;
    logic      strap_r;
    logic      unused_rsv;

    // Reserved write bits are discarded
    assign unused_rsv = ^(reg_wdata & RSV_MASK);

    // Register update, first-touch enable and strap capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            en_q    <= 1'b0;
            strap_r <= strap_in;
        end else begin
            if (reg_wr) begin
                cfg_q.size     <= reg_wdata[SIZE_LSB +: SIZE_W];
                cfg_q.dis_addr <= reg_wdata[DA_BIT];
                cfg_q.psram    <= reg_wdata[PS_BIT];
                cfg_q.rdy_ign  <= reg_wdata[RM_BIT];
                cfg_q.ws       <= reg_wdata[WS_LSB +: WS_W];
            end
            if (reg_wr || reg_rd) begin
                en_q <= 1'b1;
            end
        end
    end

    // Read data assembly with reserved ones
    always_comb begin
        reg_rdata                      = RSV_MASK;
        reg_rdata[SIZE_LSB +: SIZE_W]  = cfg_q.size;
        reg_rdata[DA_BIT]              = cfg_q.dis_addr;
        reg_rdata[PS_BIT]              = cfg_q.psram;
        reg_rdata[RM_BIT]              = cfg_q.rdy_ign;
        reg_rdata[WS_LSB +: WS_W]      = cfg_q.ws;
    end

    assign size      = cfg_q.size;
    assign dis_addr  = cfg_q.dis_addr;
    assign rdy_ign   = cfg_q.rdy_ign;
    assign ws        = cfg_q.ws;
    assign cs_enable = en_q;
    assign strap_q   = strap_r;

    AST_WR_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[SIZE_LSB +: SIZE_W] == $past(reg_wdata[SIZE_LSB +: SIZE_W]))); // R7
    AST_WR_PSRAM: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[PS_BIT] == $past(reg_wdata[PS_BIT]))); // R7
    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cs_enable |=> cs_enable); // R2
    AST_EN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |=> cs_enable); // R2

endmodule

// File: rtl/lrcs_decode.sv
// Module: lrcs_decode
// Decides whether an address lies inside the low region. The region is
// based at zero and sized in blocks of 2**BLK_SHIFT bytes, with the size
// code applied as a mask on the block-select bits.
// Assumes ADDR_W > BLK_SHIFT + SIZE_W or equal.
module lrcs_decode
    import lrcs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BLK_SHIFT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic              hit
);

    localparam int TOP_LSB = BLK_SHIFT + SIZE_W;

    logic              upper_zero;
    logic [SIZE_W-1:0] blk_sel;
    logic              unused_low;

    assign blk_sel    = addr[TOP_LSB-1:BLK_SHIFT];
    assign unused_low = ^addr[BLK_SHIFT-1:0];

    // Bits above the maximum region must all be zero
    generate
        if (ADDR_W > TOP_LSB) begin : g_upper
            assign upper_zero = ~|addr[ADDR_W-1:TOP_LSB];
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    // Mask decode of the block-select bits
    always_comb begin
        hit = upper_zero && ((blk_sel & ~size) == '0);
    end

    AST_BASE_BLOCK_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_zero && blk_sel == '0) |-> hit); // R1
    AST_ABOVE_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        !upper_zero |-> !hit); // R1

endmodule

// File: rtl/lrcs_wait.sv
// Module: lrcs_wait
// Counts the programmed wait states of an open cycle and forms the
// combined ready from the count and external ready.
// Assumes load is a single-cycle pulse at the start of a matching cycle.
module lrcs_wait
    import lrcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WS_W-1:0] ws_in,
    input  logic            active,
    input  logic            ext_rdy,
    input  logic            rdy_ign,
    output logic            rdy_out
);

    logic [WS_W-1:0] cnt;
    logic            wait_done;

    // Load at cycle start, count down while the cycle is open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= ws_in;
        end else if (active && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign wait_done = (cnt == '0);

    // Combined ready toward the bus unit
    always_comb begin
        rdy_out = active && wait_done && (rdy_ign || ext_rdy);
    end

    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_done |-> !rdy_out); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load && !wait_done) |=> (cnt == $past(cnt) - 1'b1)); // R3
    AST_EXT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_ign && !ext_rdy) |-> !rdy_out); // R5
    AST_IGN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wait_done && rdy_ign) |-> rdy_out); // R4

endmodule

// File: rtl/lrcs_unit.sv
// Module: lrcs_unit
// Top of the low-region chip select unit: decodes bus cycles against the
// programmed region, holds the chip select for the open cycle, and drives
// combined ready and the address-phase suppression request.
// Assumes a new bus_start only arrives after the previous cycle closed.
module lrcs_unit
    import lrcs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BLK_SHIFT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_addr_en,
    input  logic              bus_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ext_rdy,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              cs_n,
    output logic              rdy_out,
    output logic              addr_off
);

    logic [SIZE_W-1:0] size;
    logic              dis_addr;
    logic              rdy_ign;
    logic [WS_W-1:0]   ws;
    logic              cs_enable;
    logic              strap_q;
    logic              hit;
    logic              start_hit;
    logic              active;

    lrcs_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_in  (strap_addr_en),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .size      (size),
        .dis_addr  (dis_addr),
        .rdy_ign   (rdy_ign),
        .ws        (ws),
        .cs_enable (cs_enable),
        .strap_q   (strap_q)
    );

    lrcs_decode #(
        .ADDR_W    (ADDR_W),
        .BLK_SHIFT (BLK_SHIFT)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .size  (size),
        .hit   (hit)
    );

    assign start_hit = bus_start && !active && hit && cs_enable;

    lrcs_wait u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_hit),
        .ws_in   (ws),
        .active  (active),
        .ext_rdy (ext_rdy),
        .rdy_ign (rdy_ign),
        .rdy_out (rdy_out)
    );

    // Cycle-open flag: set by a matching start, cleared after ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (start_hit) begin
            active <= 1'b1;
        end else if (rdy_out) begin
            active <= 1'b0;
        end
    end

    assign cs_n     = !active;
    assign addr_off = active && dis_addr && strap_q;

    AST_CS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_enable |-> cs_n); // R2
    AST_RDY_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_out |-> !cs_n); // R8
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_out |=> cs_n); // R8
    AST_CS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && cs_n && hit && cs_enable) |=> !cs_n); // R8
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && cs_n && !hit) |=> cs_n); // R1
    AST_OFF_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_q |-> !addr_off); // R6
    AST_OFF_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_off |-> !cs_n); // R6

endmodule

// File: tb/sim_lrcs_unit.sv
// Bench: sweeps size codes, wait states, ready modes and strap settings,
// computing expected chip select and ready timing arithmetically.
module sim_lrcs_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_addr_en = 1'b0;
    logic        bus_start = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        ext_rdy = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cs_n;
    logic        rdy_out;
    logic        addr_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lrcs_unit u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_addr_en (strap_addr_en),
        .bus_start     (bus_start),
        .bus_addr      (bus_addr),
        .ext_rdy       (ext_rdy),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .cs_n          (cs_n),
        .rdy_out       (rdy_out),
        .addr_off      (addr_off)
    );

    function automatic logic [15:0] mk(input int sz, input bit da, input bit ps,
                                       input bit rm, input int w);
        logic [15:0] v;
        v = '0;
        v[14:12] = sz[2:0];
        v[7] = da;
        v[6] = ps;
        v[2] = rm;
        v[1:0] = w[1:0];
        return v;
    endfunction

    // Listed codes use the arithmetic end address, others the bit mask
    function automatic bit exp_hit(input int code, input logic [19:0] a);
        int blk;
        if (code == 0 || code == 1 || code == 3 || code == 7)
            return int'(a) < ((code + 1) << 16);
        blk = int'(a) >> 16;
        return (blk < 8) && ((blk & ~code & 7) == 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_addr_en = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        strap_addr_en = ~strap;
    endtask

    task automatic reg_write(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // One bus cycle; kexp = cycle index of first ready, -1 for no select.
    // lowlen = number of leading cycles with ext_rdy held low.
    task automatic access(input logic [19:0] a, input int kexp, input int lowlen,
                          input bit off_exp, input string req, input bit same_wr,
                          input logic [15:0] wv);
        int  got_k;
        bit  cs_bad;
        bit  off_bad;
        got_k = -1;
        cs_bad = 1'b0;
        off_bad = 1'b0;
        @(negedge clk);
        bus_start = 1'b1;
        bus_addr = a;
        if (same_wr) begin
            reg_wr = 1'b1;
            reg_wdata = wv;
        end
        @(negedge clk);
        bus_start = 1'b0;
        reg_wr = 1'b0;
        for (int k = 0; k < 12; k++) begin
            ext_rdy = (k >= lowlen);
            #1;
            if (kexp >= 0) begin
                if (cs_n) cs_bad = 1'b1;
                if (addr_off != off_exp) off_bad = 1'b1;
            end else begin
                if (!cs_n || addr_off) cs_bad = 1'b1;
            end
            if (rdy_out && got_k < 0) got_k = k;
            @(negedge clk);
            if (got_k >= 0) break;
        end
        ext_rdy = 1'b1;
        #1;
        check(got_k == kexp && !cs_bad, req, got_k, kexp);
        if (kexp >= 0) begin
            check(cs_n, "R8 release", int'(cs_n), 1);
            check(!off_bad, "R6", int'(!off_bad), 1);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog timeout");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        logic [19:0] alist [10];
        alist = '{20'h00000, 20'h0FFFF, 20'h10000, 20'h1FFFF, 20'h20000,
                  20'h3FFFF, 20'h40000, 20'h7FFFF, 20'h80000, 20'hFFFFF};

        // Reset with strap high; no select before first register access
        do_reset(1'b1);
        #1 check(cs_n && !rdy_out && !addr_off, "R2 reset outputs", int'(cs_n), 1);
        access(20'h00000, -1, 0, 1'b0, "R2 dead before access", 1'b0, '0);
        reg_read(rv);
        check(rv == 16'h8F38, "R7 reset value", rv, 16'h8F38);
        // Read alone enables: size 000, 0 waits, ext ready honoured
        access(20'h00000, 0, 0, 1'b0, "R2 enabled by read", 1'b0, '0);
        access(20'h00000, 2, 2, 1'b0, "R5 ext low two cycles", 1'b0, '0);

        // Sweep every size code and wait count with external ready ignored
        for (int sz = 0; sz < 8; sz++) begin
            for (int w = 0; w < 4; w++) begin
                reg_write(mk(sz, 1'b1, w[0], 1'b1, w));
                reg_read(rv);
                check(rv == (mk(sz, 1'b1, w[0], 1'b1, w) | 16'h8F38), "R7 readback",
                      rv, mk(sz, 1'b1, w[0], 1'b1, w) | 16'h8F38);
                foreach (alist[i]) begin
                    access(alist[i], exp_hit(sz, alist[i]) ? w : -1, 7, 1'b1,
                           "R1/R3/R4 sweep", 1'b0, '0);
                end
            end
        end

        // Ready mode 0: ready at the later of wait count and ext ready
        for (int w = 0; w < 4; w++) begin
            reg_write(mk(7, 1'b0, 1'b0, 1'b0, w));
            for (int l = 0; l < 6; l++) begin
                access(20'h5A5A5, (l > w) ? l : w, l, 1'b0, "R5 combined ready", 1'b0, '0);
            end
        end

        // Write coinciding with start uses the old size (R9)
        reg_write(mk(0, 1'b0, 1'b0, 1'b1, 1));
        access(20'h40000, -1, 0, 1'b0, "R9 old size applies", 1'b1, mk(7, 1'b0, 1'b0, 1'b1, 1));
        access(20'h40000, 1, 0, 1'b0, "R9 new size next cycle", 1'b0, '0);

        // Strap low: disable-address bit has no effect
        do_reset(1'b0);
        access(20'h00000, -1, 0, 1'b0, "R2 dead after second reset", 1'b1,
               mk(7, 1'b1, 1'b0, 1'b1, 1));
        access(20'h12345, 1, 0, 1'b0, "R6 strap low no suppression", 1'b0, '0);
        access(20'h80000, -1, 0, 1'b0, "R8 outside region quiet", 1'b0, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule